// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Data Path

This block is a single-port synchronous word memory with a 32-bit word split into four 8-bit lanes. The address, write data, the three chip enables and the write controls are all registered on the rising clock edge, and a write is finished within the cycle that captured it. A caller may present a new word address on every cycle with no wait states. Reads take one of two latencies, picked by a static mode input. With the mode low, the array output goes straight to the data pins. With the mode high, an extra output register sits in the read path.

The shared data bus is carried at the chip level as a pad triple. `dq_i` is the incoming data, `dq_o` is the outgoing data, and `dq_oe_o` is the pad drive enable, so that `dq_oe_o` low stands for a high-impedance bus. The output enable and the sleep input act combinationally on the drive enable. Sleep also stops the block from capturing anything, and the stored words are kept. A deselect goes through only the capture register, while a read goes through both the capture register and the output register. Because of this, the bus is released in the cycle after the last read's data window and is never held for an extra cycle.

Top module: `pipe_sram`

## Requirements
- R1: With `reg_out_i` low, a read captured at edge N drives `dq_oe_o` high and `dq_o` equal to the stored word from edge N until edge N+1. A read is a selected cycle that is not a write.
- R2: With `reg_out_i` high, a read captured at edge N drives the stored word from edge N+1 until edge N+2.
- R3: A cycle is selected only when `cs0_ni` is low, `cs1_i` is high and `cs2_ni` is low. Any other combination is a deselect: it writes nothing, and the bus is released one capture stage after it (from edge N with the mode low, from edge N+1 with the mode high).
- R4: When `lane_wr_en_i` is high and `all_wr_i` is low on a selected cycle, bit j of `lane_sel_i` enables writing bits [8j+7:8j] of `dq_i`. Unselected lanes keep their old contents.
- R5: When `all_wr_i` is high on a selected cycle, all four lanes are written, whatever `lane_wr_en_i` and `lane_sel_i` are.
- R6: When `lane_wr_en_i` is high, `lane_sel_i` is all zero and `all_wr_i` is low, the cycle is a read and no lane changes.
- R7: `dq_oe_o` is high only while `out_en_i` is high. `out_en_i` acts without waiting for a clock edge.
- R8: While `sleep_i` is high, `dq_oe_o` is low at once and each capture is treated as a deselect, so no write happens. Stored words are unchanged afterwards.
- R9: A read one cycle after a write to the same address returns the new word. A write one cycle after a read to the same address does not change the data of that earlier read.
- R10: While `rst_ni` is low, and right after it goes high, `dq_oe_o` is low.
- R11: `reg_out_i` may change between cycles. The data window in force is the one chosen by its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low reset of the pipeline flags |
| reg_out_i | input | 1 | 1 = registered read output, 0 = flow-through |
| cs0_ni | input | 1 | Chip enable, active low |
| cs1_i | input | 1 | Chip enable, active high |
| cs2_ni | input | 1 | Chip enable, active low |
| addr_i | input | AW | Word address |
| lane_wr_en_i | input | 1 | Lane write enable, qualifies `lane_sel_i` |
| lane_sel_i | input | 4 | Per-lane write selects, bit j = bits [8j+7:8j] |
| all_wr_i | input | 1 | Whole-word write |
| dq_i | input | 32 | Bus data in |
| out_en_i | input | 1 | Asynchronous output enable, active high |
| sleep_i | input | 1 | Sleep, active high |
| dq_o | output | 32 | Bus data out (zero when not driven) |
| dq_oe_o | output | 1 | Bus drive enable; low = high impedance |

## Verification
The bench keeps two expected read results, one for the cycle just captured and one for the cycle before it. In flow-through mode a read is due in the window right after its own capture edge. In registered mode it is due one edge later. At every falling edge the bench compares `dq_oe_o` and `dq_o` against the entry that the current mode selects. It does this before it drives new inputs, so the asynchronous enables still hold the values that belong to that window. Writes, ignored writes and sleep are checked through later reads of a reference word array.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lmask_t;
endpackage

// File: rtl/psr_capture.sv
// Input capture stage: decodes select/write from the pins, registers read command.
module psr_capture
    import pipe_sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cs0_ni,
    input  logic          cs1_i,
    input  logic          cs2_ni,
    input  logic          sleep_i,
    input  logic [AW-1:0] addr_i,
    input  logic          lane_wr_en_i,
    input  lmask_t        lane_sel_i,
    input  logic          all_wr_i,
    output lmask_t        wr_mask_o,
    output logic          rd_q_o,
    output logic [AW-1:0] addr_q_o
);
    typedef struct packed {
        logic          rd;
        logic [AW-1:0] addr;
    } cap_t;

    cap_t cap_d, cap_q;
    logic sel;
    logic is_wr;

    always_comb begin
        sel   = !cs0_ni && cs1_i && !cs2_ni && !sleep_i;
        is_wr = all_wr_i || (lane_wr_en_i && (lane_sel_i != '0));
        if (!sel)          wr_mask_o = '0;
        else if (all_wr_i) wr_mask_o = '1;
        else if (lane_wr_en_i) wr_mask_o = lane_sel_i;
        else               wr_mask_o = '0;

        cap_d      = cap_q;
        cap_d.rd   = sel && !is_wr;
        cap_d.addr = addr_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    assign rd_q_o   = cap_q.rd;
    assign addr_q_o = cap_q.addr;
endmodule

// File: rtl/psr_lane.sv
// One byte lane of the array: synchronous write, combinational read.
module psr_lane
    import pipe_sram_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  lane_t         wdata_i,
    input  logic [AW-1:0] raddr_i,
    output lane_t         rdata_o
);
    lane_t store [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) store[waddr_i] <= wdata_i;
    end

    assign rdata_o = store[raddr_i];
endmodule

// File: rtl/psr_outstage.sv
// Output stage: optional data register, mode mux and pad drive gating.
module psr_outstage
    import pipe_sram_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  reg_out_i,
    input  logic  out_en_i,
    input  logic  sleep_i,
    input  logic  rd_i,
    input  word_t rdata_i,
    output word_t dq_o,
    output logic  dq_oe_o
);
    typedef struct packed {
        logic  rd;
        word_t data;
    } out_t;

    out_t out_d, out_q;
    logic  valid;
    word_t sel_data;

    always_comb begin
        out_d      = out_q;
        out_d.rd   = rd_i;
        if (rd_i) out_d.data = rdata_i;

        valid    = reg_out_i ? out_q.rd   : rd_i;
        sel_data = reg_out_i ? out_q.data : rdata_i;
        dq_oe_o  = valid && out_en_i && !sleep_i;
        dq_o     = dq_oe_o ? sel_data : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
    import pipe_sram_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          reg_out_i,
    input  logic          cs0_ni,
    input  logic          cs1_i,
    input  logic          cs2_ni,
    input  logic [AW-1:0] addr_i,
    input  logic          lane_wr_en_i,
    input  logic [3:0]    lane_sel_i,
    input  logic          all_wr_i,
    input  logic [31:0]   dq_i,
    input  logic          out_en_i,
    input  logic          sleep_i,
    output logic [31:0]   dq_o,
    output logic          dq_oe_o
);
    lmask_t        wr_mask;
    logic          cap_rd;
    logic [AW-1:0] cap_addr;
    word_t         rdata;

    psr_capture #(.AW(AW)) cap_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cs0_ni       (cs0_ni),
        .cs1_i        (cs1_i),
        .cs2_ni       (cs2_ni),
        .sleep_i      (sleep_i),
        .addr_i       (addr_i),
        .lane_wr_en_i (lane_wr_en_i),
        .lane_sel_i   (lane_sel_i),
        .all_wr_i     (all_wr_i),
        .wr_mask_o    (wr_mask),
        .rd_q_o       (cap_rd),
        .addr_q_o     (cap_addr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        psr_lane #(.DEPTH(DEPTH), .AW(AW)) lane_i (
            .clk_i   (clk_i),
            .we_i    (wr_mask[g]),
            .waddr_i (addr_i),
            .wdata_i (dq_i[g*LANE_W +: LANE_W]),
            .raddr_i (cap_addr),
            .rdata_o (rdata[g*LANE_W +: LANE_W])
        );
    end

    psr_outstage out_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .reg_out_i (reg_out_i),
        .out_en_i  (out_en_i),
        .sleep_i   (sleep_i),
        .rd_i      (cap_rd),
        .rdata_i   (rdata),
        .dq_o      (dq_o),
        .dq_oe_o   (dq_oe_o)
    );
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       reg_out_i,
    input logic       cs0_ni,
    input logic       cs1_i,
    input logic       cs2_ni,
    input logic       lane_wr_en_i,
    input logic [3:0] lane_sel_i,
    input logic       all_wr_i,
    input logic       out_en_i,
    input logic       sleep_i,
    input logic       dq_oe_o,
    input logic       cap_rd,
    input logic [3:0] wr_mask
);
    logic armed_q;
    logic sel_now;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    assign sel_now = !cs0_ni && cs1_i && !cs2_ni && !sleep_i;

    p_bus_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dq_oe_o |-> (out_en_i && !sleep_i));

    p_flow_read_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_rd && !reg_out_i && out_en_i && !sleep_i) |-> dq_oe_o);

    p_pipe_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(cap_rd) && reg_out_i && out_en_i && !sleep_i) |-> dq_oe_o);

    p_desel_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && !cap_rd && (!reg_out_i || !$past(cap_rd))) |-> !dq_oe_o);

    p_sleep_nowrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_i |-> (wr_mask == 4'b0));

    p_lane_subset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !all_wr_i |-> ((wr_mask & ~lane_sel_i) == 4'b0));

    p_global_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_now && all_wr_i) |-> (wr_mask == 4'hF));

    p_empty_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!all_wr_i && lane_wr_en_i && lane_sel_i == 4'b0) |-> (wr_mask == 4'b0));
endmodule

bind pipe_sram pipe_sram_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_out_i    (reg_out_i),
    .cs0_ni       (cs0_ni),
    .cs1_i        (cs1_i),
    .cs2_ni       (cs2_ni),
    .lane_wr_en_i (lane_wr_en_i),
    .lane_sel_i   (lane_sel_i),
    .all_wr_i     (all_wr_i),
    .out_en_i     (out_en_i),
    .sleep_i      (sleep_i),
    .dq_oe_o      (dq_oe_o),
    .cap_rd       (cap_rd),
    .wr_mask      (wr_mask)
);

// File: tb/pipe_sram_tb_top.sv
module pipe_sram_tb_top;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_out = 1'b1;
    logic          cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          lane_wr_en = 1'b0;
    logic [3:0]    lane_sel = '0;
    logic          all_wr = 1'b0;
    logic [31:0]   dq_i = '0;
    logic          oe = 1'b1;
    logic          sleep = 1'b0;
    logic [31:0]   dq_o;
    logic          dq_oe;

    always #5 clk = ~clk;

    pipe_sram #(.DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_out_i(reg_out),
        .cs0_ni(cs0_n), .cs1_i(cs1), .cs2_ni(cs2_n), .addr_i(addr),
        .lane_wr_en_i(lane_wr_en), .lane_sel_i(lane_sel), .all_wr_i(all_wr),
        .dq_i(dq_i), .out_en_i(oe), .sleep_i(sleep),
        .dq_o(dq_o), .dq_oe_o(dq_oe)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    logic [31:0] ref_mem [DEPTH];
    bit          cur_rd = 0, prev_rd = 0;
    logic [31:0] cur_data = '0, prev_data = '0;
    string       cur_tag = "R10", prev_tag = "R10";
    bit          cur_oe = 1, cur_sleep = 0, cur_mode = 1;

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
        logic [31:0] r = old;
        for (int j = 0; j < 4; j++) if (m[j]) r[j*8 +: 8] = nw[j*8 +: 8];
        return r;
    endfunction

    task automatic check_now();
        bit valid = cur_mode ? prev_rd : cur_rd;
        logic [31:0] edata = cur_mode ? prev_data : cur_data;
        bit eoe = valid && cur_oe && !cur_sleep;
        string tag;
        if (cur_sleep)   tag = "R8";
        else if (!cur_oe) tag = "R7";
        else if (valid)  tag = {cur_mode ? "R2/R11 " : "R1/R11 ", cur_mode ? prev_tag : cur_tag};
        else             tag = "R3";
        n_chk++;
        if (dq_oe !== eoe) begin
            n_bad++;
            $display("FAIL %s drive: got %0b exp %0b t=%0t", tag, dq_oe, eoe, $time);
        end else if (eoe) begin
            n_chk++;
            if (dq_o !== edata) begin
                n_bad++;
                $display("FAIL %s data: got %h exp %h t=%0t", tag, dq_o, edata, $time);
            end
        end
    endtask

    // one bus cycle: check the window in force, then drive the next capture
    task automatic cyc(bit c0n, bit c1, bit c2n, bit slp, bit bwe, bit gw,
                       logic [3:0] bs, logic [AW-1:0] a, logic [31:0] d,
                       bit o, bit mode, string tag);
        bit sel, wr;
        logic [3:0] m;
        @(negedge clk);
        check_now();
        cs0_n = c0n; cs1 = c1; cs2_n = c2n; sleep = slp; lane_wr_en = bwe;
        all_wr = gw; lane_sel = bs; addr = a; dq_i = d; oe = o; reg_out = mode;
        sel = !c0n && c1 && !c2n && !slp;
        wr  = gw || (bwe && bs != 4'b0);
        m   = !sel ? 4'b0 : (gw ? 4'hF : (bwe ? bs : 4'b0));
        prev_rd = cur_rd; prev_data = cur_data; prev_tag = cur_tag;
        cur_rd = sel && !wr;
        cur_data = ref_mem[a];
        cur_tag = tag;
        cur_oe = o; cur_sleep = slp; cur_mode = mode;
        ref_mem[a] = merge(ref_mem[a], d, m);
    endtask

    task automatic rd(logic [AW-1:0] a, bit mode, string tag);
        cyc(0, 1, 0, 0, 0, 0, 4'h0, a, $urandom, 1, mode, tag);
    endtask
    task automatic idle(bit mode);
        cyc(1, 0, 1, 0, 0, 0, 4'h0, '0, '0, 1, mode, "R3");
    endtask

    initial begin
        void'($urandom(32'd7321));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (dq_oe !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 drive in reset: got %0b exp 0", dq_oe);
        end
        rst_n = 1'b1;

        // fill every word with a whole-word write (R5)
        for (int i = 0; i < DEPTH; i++)
            cyc(0, 1, 0, 0, $urandom % 2, 1, 4'($urandom), AW'(i), $urandom, 1, 1, "R5");

        // R4: byte-lane write, read back both modes
        cyc(0, 1, 0, 0, 1, 0, 4'b0101, 8'd10, 32'hAABBCCDD, 1, 1, "R4");
        rd(8'd10, 1, "R4"); rd(8'd10, 0, "R4"); idle(0);
        // R5: global write with lane controls idle
        cyc(0, 1, 0, 0, 0, 1, 4'b0000, 8'd11, 32'h11223344, 1, 0, "R5");
        rd(8'd11, 0, "R5"); idle(0);
        // R6: lane enable with no lanes selected is a read
        cyc(0, 1, 0, 0, 1, 0, 4'b0000, 8'd11, 32'hFFFFFFFF, 1, 0, "R6");
        cyc(0, 1, 0, 0, 1, 0, 4'b0000, 8'd11, 32'hFFFFFFFF, 1, 1, "R6");
        idle(1); idle(1);
        // R3: each chip enable inactive on a write attempt, then read back
        cyc(1, 1, 0, 0, 0, 1, 4'h0, 8'd12, 32'hDEAD0001, 1, 1, "R3");
        cyc(0, 0, 0, 0, 0, 1, 4'h0, 8'd12, 32'hDEAD0002, 1, 1, "R3");
        cyc(0, 1, 1, 0, 0, 1, 4'h0, 8'd12, 32'hDEAD0003, 1, 1, "R3");
        rd(8'd12, 1, "R3"); idle(1); idle(1);
        // R8: write during sleep ignored, bus off at once
        rd(8'd13, 0, "R8");
        cyc(0, 1, 0, 1, 0, 1, 4'h0, 8'd13, 32'h5EE95EE9, 1, 0, "R8");
        rd(8'd13, 0, "R8"); idle(0);
        // R7: output enable low during a read
        cyc(0, 1, 0, 0, 0, 0, 4'h0, 8'd14, 32'h0, 0, 0, "R7");
        idle(0);
        // R9: read right after write, write right after read (both modes)
        cyc(0, 1, 0, 0, 0, 1, 4'h0, 8'd15, 32'h0BADF00D, 1, 0, "R9");
        rd(8'd15, 0, "R9");
        cyc(0, 1, 0, 0, 1, 0, 4'hF, 8'd15, 32'h12345678, 1, 0, "R9");
        rd(8'd15, 1, "R9");
        cyc(0, 1, 0, 0, 0, 1, 4'h0, 8'd15, 32'h87654321, 1, 1, "R9");
        rd(8'd15, 1, "R9"); idle(1); idle(1);

        // constrained random traffic
        begin
            bit mode = 1;
            for (int k = 0; k < 4000; k++) begin
                int r = $urandom % 16;
                logic [AW-1:0] a = AW'($urandom % 32);
                logic [31:0] d = $urandom;
                bit o = ($urandom % 8) != 0;
                if ($urandom % 32 == 0) mode = ~mode;
                case (r)
                    0:  cyc(1, 1, 0, 0, 0, 1, 4'h0, a, d, o, mode, "R3");
                    1:  cyc(0, 0, 0, 0, 1, 0, 4'hF, a, d, o, mode, "R3");
                    2:  cyc(0, 1, 1, 0, 0, 0, 4'h0, a, d, o, mode, "R3");
                    3:  cyc(0, 1, 0, 1, 0, 1, 4'h0, a, d, o, mode, "R8");
                    4, 5: cyc(0, 1, 0, 0, 1, 0, 4'($urandom), a, d, o, mode, "R4");
                    6:  cyc(0, 1, 0, 0, $urandom % 2, 1, 4'($urandom), a, d, o, mode, "R5");
                    7:  cyc(0, 1, 0, 0, 1, 0, 4'h0, a, d, o, mode, "R6");
                    default: cyc(0, 1, 0, 0, 0, 0, 4'h0, a, d, o, mode, "R9");
                endcase
            end
        end
        idle(1); idle(1);
        @(negedge clk);
        check_now();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got hang exp finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule